// File: doc/BRIEF.md
# Serial Write Frame Decoder

This block sits behind a byte receiver that already handles start bits, stop bits and bit sampling. It turns the stream of received bytes into register writes. A write transaction opens with a fixed sync byte. A header byte follows, carrying the payload length and the target's device ID. Next come a start register address, the payload bytes and a closing check byte. The block only writes to the register file once it has confirmed that the check byte matches the CRC it computed itself.

The payload is held in a small buffer until the check byte has arrived. When the check passes, the block pulses a watchdog-refresh output. It then drains the buffer to the register write port at one byte per clock, starting at the given address and counting upwards. The block discards a frame entirely in any of these cases: the check fails, the device ID belongs to another target, a byte arrives with a framing error, or the line stays silent for too long between bytes. A discarded frame never touches the watchdog.

Top module: `wfd_frame_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `wr_en`, `wd_kick` and `crc_err` are low until a frame is handled.
- R2: Only a byte equal to 0x55 starts a frame. While the decoder is idle, any other byte, and any byte flagged with a framing error, is dropped with no effect.
- R3: Bits [7:6] of the header byte set the payload length: 00 gives 1 byte, 01 gives 4, 10 gives 16 and 11 gives 24.
- R4: If bits [5:0] of the header byte differ from `dev_id`, the decoder consumes the rest of the frame without acting on it (address, payload and check byte). It produces no write and no pulse, and it accepts the next sync byte that follows at once.
- R5: The check value is CRC-8 with polynomial 0x31 and seed 0xFF. The bits of each byte are fed LSB first: the feedback bit is crc[7] XOR the data bit, the register shifts left, and the result is XORed with 0x31 when the feedback bit is 1. There is no final XOR. It covers the header, the address and all payload bytes, in that order.
- R6: When the check byte matches, payload byte i is written to address (start + i) modulo 256. The writes happen on consecutive clocks and in the order the bytes were received.
- R7: When the check byte does not match, nothing is written, `crc_err` pulses for exactly one clock and `wd_kick` stays low.
- R8: When the check passes, `wd_kick` pulses for exactly one clock, in the cycle just before the first write.
- R9: A byte with `rx_frame_err` set, arriving anywhere after the sync byte and up to the check byte, aborts the frame. It produces no write and no pulse.
- R10: Inside a frame, up to `gap_limit` idle clocks between bytes are allowed. Once `gap_limit`+1 idle clocks have passed, the frame is aborted with no write and no pulse.
- R11: Bytes that arrive while the buffered payload is being written out are ignored, including the sync value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-clock strobe for a received byte |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | The byte in this cycle had a bad stop bit |
| dev_id | input | 6 | Device ID this decoder answers to |
| gap_limit | input | 16 | Maximum number of idle clocks allowed between bytes of a frame |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 8 | Register write data |
| wd_kick | output | 1 | One-clock watchdog refresh after a verified frame |
| crc_err | output | 1 | One-clock pulse when the check byte does not match |

## Verification
The decoder is driven with good frames of all four lengths and with varied start addresses, one of which wraps past 0xFF. This shows the length decode and the address increment working. Each good frame is paired with a faulty variant: a flipped check bit, a foreign device ID, a framing error partway through the payload, or an inter-byte gap one clock longer than allowed. Only the foreign-ID and gap cases can tell apart a decoder that skips or times out correctly from one that merely resynchronises. A gap of exactly the limit confirms that the boundary itself is accepted. Idle junk bytes and a sync byte sent during write-out, followed by a frame with no sync byte, check that decoding only starts from a proper sync.

// File: rtl/wfd_pkg.sv
package wfd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_ADDR,
      ST_DATA,
      ST_CHECK,
      ST_SKIP,
      ST_DRAIN
   } wfd_state_e;

   // payload byte count selected by the two header length bits (R3)
   function automatic int unsigned pl_count(input logic [1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 16;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/wfd_crc8_step.sv
module wfd_crc8_step #(
   parameter int unsigned    CRC_W = 8,
   parameter int unsigned    BYTE_W = 8,
   parameter logic [CRC_W-1:0] POLY = 8'h31
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [CRC_W-1:0]  crc_out
);

   logic [BYTE_W:0][CRC_W-1:0] chain;

   assign chain[0] = crc_in;

   for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      logic fb;
      assign fb          = chain[b][CRC_W-1] ^ byte_in[b];
      assign chain[b+1]  = {chain[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = chain[BYTE_W];

   if (CRC_W < 2) begin : g_bad_width
      $error("wfd_crc8_step: CRC_W must be at least 2");
   end

endmodule

// File: rtl/wfd_payload_buf.sv
module wfd_payload_buf #(
   parameter int unsigned DEPTH = 24,
   parameter int unsigned WIDTH = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [WIDTH-1:0] wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata = mem[ridx];

   // R3: the longest payload still lands inside the buffer
   p_buf_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(widx) < DEPTH))
      else $error("payload index out of range");

   if (DEPTH < 2) begin : g_bad_depth
      $error("wfd_payload_buf: DEPTH must be at least 2");
   end

endmodule

// File: rtl/wfd_gap_timer.sv
module wfd_gap_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             byte_seen,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   logic [CNT_W-1:0] idle_cnt;

   assign expired = run && !byte_seen && (idle_cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= '0;
      end else if (!run || byte_seen || expired) begin
         idle_cnt <= '0;
      end else begin
         idle_cnt <= idle_cnt + 1'b1;
      end
   end

   // R10: an expiry is always followed by a fresh count
   p_restart_after_expiry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> (idle_cnt == '0))
      else $error("gap counter not cleared after expiry");

endmodule

// File: rtl/wfd_frame_decoder.sv
module wfd_frame_decoder
   import wfd_pkg::*;
#(
   parameter int unsigned     DATA_W      = 8,
   parameter int unsigned     ADDR_W      = 8,
   parameter int unsigned     ID_W        = 6,
   parameter int unsigned     MAX_PAYLOAD = 24,
   parameter int unsigned     GAP_W       = 16,
   parameter logic [DATA_W-1:0] SYNC_CODE = 8'h55,
   parameter logic [DATA_W-1:0] CRC_POLY  = 8'h31,
   parameter logic [DATA_W-1:0] CRC_SEED  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_frame_err,
   input  logic [ID_W-1:0]   dev_id,
   input  logic [GAP_W-1:0]  gap_limit,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wd_kick,
   output logic              crc_err
);

   localparam int unsigned IDX_W  = $clog2(MAX_PAYLOAD);
   localparam int unsigned SKIP_W = $clog2(MAX_PAYLOAD + 3);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("wfd_frame_decoder: DATA_W must be 8");
   end
   if (ID_W != DATA_W - 2) begin : g_bad_id_w
      $error("wfd_frame_decoder: ID_W must leave two header bits for length");
   end
   if (MAX_PAYLOAD < 24) begin : g_bad_depth
      $error("wfd_frame_decoder: MAX_PAYLOAD must hold the 24-byte burst");
   end

   wfd_state_e         state_q;
   logic [DATA_W-1:0]  crc_q;
   logic [DATA_W-1:0]  crc_next;
   logic [DATA_W-1:0]  start_q;
   logic [IDX_W-1:0]   last_q;
   logic [IDX_W-1:0]   idx_q;
   logic [SKIP_W-1:0]  skip_q;
   logic [DATA_W-1:0]  buf_rd;
   logic               in_frame;
   logic               good_byte;
   logic               bad_byte;
   logic               gap_expired;
   logic               buf_we;
   logic [IDX_W-1:0]   hdr_last;

   assign in_frame  = (state_q != ST_IDLE) && (state_q != ST_DRAIN);
   assign good_byte = rx_valid && !rx_frame_err;
   assign bad_byte  = rx_valid && rx_frame_err;
   assign buf_we    = (state_q == ST_DATA) && good_byte;
   assign hdr_last  = IDX_W'(pl_count(rx_data[DATA_W-1 -: 2]) - 1);

   wfd_crc8_step #(
      .CRC_W  (DATA_W),
      .BYTE_W (DATA_W),
      .POLY   (CRC_POLY)
   ) i_crc (
      .crc_in  (crc_q),
      .byte_in (rx_data),
      .crc_out (crc_next)
   );

   wfd_payload_buf #(
      .DEPTH (MAX_PAYLOAD),
      .WIDTH (DATA_W)
   ) i_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (buf_we),
      .widx  (idx_q),
      .wdata (rx_data),
      .ridx  (idx_q),
      .rdata (buf_rd)
   );

   wfd_gap_timer #(
      .CNT_W (GAP_W)
   ) i_gap (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (in_frame),
      .byte_seen (rx_valid),
      .limit     (gap_limit),
      .expired   (gap_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         crc_q   <= CRC_SEED;
         start_q <= '0;
         last_q  <= '0;
         idx_q   <= '0;
         skip_q  <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         wd_kick <= 1'b0;
         crc_err <= 1'b0;
      end else begin
         wr_en   <= 1'b0;
         wd_kick <= 1'b0;
         crc_err <= 1'b0;
         if (in_frame && (bad_byte || gap_expired)) begin
            state_q <= ST_IDLE;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (good_byte && rx_data == SYNC_CODE) begin
                     state_q <= ST_HDR;
                     crc_q   <= CRC_SEED;
                  end
               end
               ST_HDR: begin
                  if (good_byte) begin
                     crc_q  <= crc_next;
                     last_q <= hdr_last;
                     if (rx_data[ID_W-1:0] == dev_id) begin
                        state_q <= ST_ADDR;
                     end else begin
                        state_q <= ST_SKIP;
                        skip_q  <= SKIP_W'(hdr_last) + SKIP_W'(2);
                     end
                  end
               end
               ST_ADDR: begin
                  if (good_byte) begin
                     crc_q   <= crc_next;
                     start_q <= rx_data;
                     idx_q   <= '0;
                     state_q <= ST_DATA;
                  end
               end
               ST_DATA: begin
                  if (good_byte) begin
                     crc_q <= crc_next;
                     idx_q <= idx_q + 1'b1;
                     if (idx_q == last_q) begin
                        state_q <= ST_CHECK;
                     end
                  end
               end
               ST_CHECK: begin
                  if (good_byte) begin
                     idx_q <= '0;
                     if (rx_data == crc_q) begin
                        state_q <= ST_DRAIN;
                        wd_kick <= 1'b1;
                     end else begin
                        state_q <= ST_IDLE;
                        crc_err <= 1'b1;
                     end
                  end
               end
               ST_SKIP: begin
                  if (good_byte) begin
                     if (skip_q == '0) begin
                        state_q <= ST_IDLE;
                     end else begin
                        skip_q <= skip_q - 1'b1;
                     end
                  end
               end
               ST_DRAIN: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ADDR_W'(start_q) + ADDR_W'(idx_q);
                  wr_data <= buf_rd;
                  idx_q   <= idx_q + 1'b1;
                  if (idx_q == last_q) begin
                     state_q <= ST_IDLE;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   // R8: a refresh is followed immediately by the first write
   p_kick_leads_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wd_kick |=> wr_en)
      else $error("no write after watchdog refresh");

   // R6: back-to-back writes step the address by one
   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)))
      else $error("write address did not increment");

   // R7: a failed check neither refreshes nor writes
   p_err_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> (!wd_kick && !wr_en))
      else $error("check failure overlapped a refresh or write");

   p_err_no_write_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |=> !wr_en)
      else $error("write after check failure");

   // R9: a framing error mid-frame returns to idle without side effects
   p_ferr_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_byte && in_frame) |=> (state_q == ST_IDLE && !wd_kick && !crc_err))
      else $error("framing error did not abort the frame");

   // R10: an expired gap returns to idle
   p_gap_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      gap_expired |=> (state_q == ST_IDLE && !wd_kick && !crc_err))
      else $error("gap timeout did not abort the frame");

   // R11: nothing received during write-out can raise a check error
   p_drain_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DRAIN) |=> !crc_err)
      else $error("byte accepted during write-out");

endmodule

// File: tb/test_wfd_frame_decoder.sv
`timescale 1ns/1ps
module test_wfd_frame_decoder;

   localparam logic [5:0]  DEV_ID    = 6'h2A;
   localparam int unsigned GAP_LIMIT = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_frame_err = 1'b0;
   logic       wr_en;
   logic [7:0] wr_addr;
   logic [7:0] wr_data;
   logic       wd_kick;
   logic       crc_err;

   int checks = 0;
   int errors = 0;
   int kicks  = 0;
   int errs   = 0;
   bit done   = 0;
   logic prev_wr = 1'b0;
   logic prev_kick = 1'b0;
   logic [15:0] exp_q [$];

   always #2 clk = ~clk;

   wfd_frame_decoder i_wfd_frame_decoder (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .rx_frame_err (rx_frame_err),
      .dev_id       (DEV_ID),
      .gap_limit    (16'(GAP_LIMIT)),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .wd_kick      (wd_kick),
      .crc_err      (crc_err)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] b);
      logic [7:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         logic fb;
         fb = r[7] ^ b[i];
         r  = {r[6:0], 1'b0};
         if (fb) r = r ^ 8'h31;
      end
      return r;
   endfunction

   function automatic int len_of(input logic [1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 16;
         default: return 24;
      endcase
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (wd_kick) kicks++;
         if (crc_err) errs++;
         if (wr_en) begin
            if (!prev_wr) chk(prev_kick == 1'b1, "R8", "kick before first write", int'(prev_kick), 1);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6", "unexpected write addr", int'(wr_addr), -1);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk({wr_addr, wr_data} == e, "R6", "write addr/data",
                   int'({wr_addr, wr_data}), int'(e));
            end
         end
         prev_wr   = wr_en;
         prev_kick = wd_kick;
      end
   end

   // called at a falling edge; leaves gap idle cycles after the byte
   task automatic send_byte(input logic [7:0] b, input bit fe, input int gap);
      rx_valid     = 1'b1;
      rx_data      = b;
      rx_frame_err = fe;
      @(negedge clk);
      rx_valid     = 1'b0;
      rx_frame_err = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic send_frame(input string tag, input logic [5:0] id, input logic [1:0] code,
                             input logic [7:0] ra, input int seed, input bit corrupt,
                             input int gap_pos, input int gap_len, input int ferr_pos,
                             input bit poke_sync, input int tail);
      logic [7:0] bytes [$];
      logic [7:0] c;
      logic [7:0] d;
      int  n;
      int  k0;
      int  e0;
      bit  aborts;
      bit  ok;
      bit  bad;
      n = len_of(code);
      c = crc_upd(8'hFF, {code, id});
      c = crc_upd(c, ra);
      bytes.push_back(8'h55);
      bytes.push_back({code, id});
      bytes.push_back(ra);
      for (int i = 0; i < n; i++) begin
         d = 8'((seed * 37 + i * 11 + 1) & 255);
         if (d == 8'h55) d = 8'h56;
         bytes.push_back(d);
         c = crc_upd(c, d);
      end
      bytes.push_back(corrupt ? (c ^ 8'h01) : c);
      aborts = (ferr_pos >= 0) || (gap_pos >= 0 && gap_len > int'(GAP_LIMIT));
      ok  = (id == DEV_ID) && !corrupt && !aborts;
      bad = (id == DEV_ID) && corrupt && !aborts;
      if (ok) begin
         for (int i = 0; i < n; i++) exp_q.push_back({8'(ra + 8'(i)), bytes[3 + i]});
      end
      k0 = kicks;
      e0 = errs;
      for (int i = 0; i < bytes.size(); i++) begin
         bit fe;
         int g;
         fe = (i == ferr_pos);
         g  = (i == gap_pos) ? gap_len : 1;
         send_byte(bytes[i], fe, g);
         if (fe || (i == gap_pos && gap_len > int'(GAP_LIMIT))) break;
      end
      if (poke_sync) send_byte(8'h55, 1'b0, 1);
      repeat (tail) @(negedge clk);
      if (tail > 0) begin
         chk(exp_q.size() == 0, tag, "writes outstanding", exp_q.size(), 0);
         chk((kicks - k0) == int'(ok), tag, "watchdog refresh count", kicks - k0, int'(ok));
         chk((errs - e0) == int'(bad), tag, "check error count", errs - e0, int'(bad));
      end
   endtask

   task automatic report();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(4ns * 200000);
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      report();
   end

   initial begin
      int k0;
      logic [7:0] c;
      repeat (3) @(negedge clk);
      // R1: quiet outputs during and after reset
      chk(!wr_en && !wd_kick && !crc_err, "R1", "outputs in reset",
          int'({wr_en, wd_kick, crc_err}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!wr_en && !wd_kick && !crc_err, "R1", "outputs after reset",
          int'({wr_en, wd_kick, crc_err}), 0);

      // R3 R5 R6: all four lengths
      send_frame("R3", DEV_ID, 2'b00, 8'h10, 1, 0, -1, 0, -1, 0, 40);
      send_frame("R5", DEV_ID, 2'b01, 8'h20, 2, 0, -1, 0, -1, 0, 40);
      send_frame("R3", DEV_ID, 2'b10, 8'h40, 3, 0, -1, 0, -1, 0, 40);
      send_frame("R3", DEV_ID, 2'b11, 8'h80, 4, 0, -1, 0, -1, 0, 40);
      // R6: address wraps past 0xFF
      send_frame("R6", DEV_ID, 2'b01, 8'hFE, 5, 0, -1, 0, -1, 0, 40);
      // R7: corrupted check byte
      send_frame("R7", DEV_ID, 2'b01, 8'h30, 6, 1, -1, 0, -1, 0, 40);
      // R4: foreign ID with a sync value as address, then a frame right behind it
      send_frame("R4", 6'h15, 2'b10, 8'h55, 7, 0, -1, 0, -1, 0, 0);
      send_frame("R4", DEV_ID, 2'b01, 8'h50, 8, 0, -1, 0, -1, 0, 40);
      // R2: junk while idle
      send_byte(8'h00, 1'b0, 1);
      send_byte(8'hAA, 1'b0, 1);
      send_byte(8'h55, 1'b1, 1);
      send_byte(8'h54, 1'b0, 1);
      send_frame("R2", DEV_ID, 2'b00, 8'h60, 9, 0, -1, 0, -1, 0, 40);
      // R9: framing error on the second payload byte
      send_frame("R9", DEV_ID, 2'b01, 8'h70, 10, 0, -1, 0, 4, 0, 40);
      send_frame("R9", DEV_ID, 2'b00, 8'h71, 11, 0, -1, 0, -1, 0, 40);
      // R10: gap at the limit is fine, one more aborts
      send_frame("R10", DEV_ID, 2'b01, 8'h90, 12, 0, 4, GAP_LIMIT, -1, 0, 40);
      send_frame("R10", DEV_ID, 2'b01, 8'hA0, 13, 0, 4, GAP_LIMIT + 1, -1, 0, 40);
      // R11: sync during write-out, then a sync-less frame must do nothing
      send_frame("R11", DEV_ID, 2'b01, 8'hB0, 14, 0, -1, 0, -1, 1, 40);
      k0 = kicks;
      c = crc_upd(8'hFF, {2'b00, DEV_ID});
      c = crc_upd(c, 8'h30);
      c = crc_upd(c, 8'h12);
      send_byte({2'b00, DEV_ID}, 1'b0, 1);
      send_byte(8'h30, 1'b0, 1);
      send_byte(8'h12, 1'b0, 1);
      send_byte(c, 1'b0, 1);
      repeat (40) @(negedge clk);
      chk(exp_q.size() == 0, "R11", "writes outstanding", exp_q.size(), 0);
      chk(kicks == k0, "R11", "refresh without sync", kicks - k0, 0);
      send_frame("R11", DEV_ID, 2'b00, 8'hC0, 15, 0, -1, 0, -1, 0, 40);
      report();
   end

endmodule